// File: doc/BRIEF.md
# Radix-256 Signed-Digit Sequential Multiplier

The block multiplies a W-bit two's-complement multiplicand by a W-bit multiplier. It retires eight multiplier bits per clock. In each iteration four signed-digit adder/subtracter stages are chained combinationally. Each stage applies one radix-4 recoded digit, so every multiple it needs comes from a shift and a sign flip of the multiplicand. The partial product stays in redundant form (a plus vector and a minus vector) between iterations and moves right by one byte per iteration. Digits shifted below the adding window are kept, so the final result is exact.

After W/8 iterations a single finishing pass adds a correction and converts the redundant value to binary. The correction is one multiplicand, added only when the multiplier is taken as unsigned and the bit left over from recoding is 1. The output is the top W+4 bits of the 2W-bit product, which keeps four bits below the operand width for later normalisation.

A caller presents operands together with a one-cycle `start` while `busy` is low. There is no back-pressure on the result. `product` is valid in the cycle `done` pulses and holds its value until the next pulse. A new `start` may be given in that same cycle.

Top module: `sdmul_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy is 0, done is 0 and product is 0.
- R2: start is accepted only while busy is 0. Once accepted, busy is 1 for exactly W/8+1 consecutive cycles.
- R3: done is high for exactly one cycle: the cycle after the (W/8+1)-th rising edge that follows the accepting edge. In that same cycle busy returns to 0.
- R4: A start given while busy is 1 has no effect: no extra done appears and the running result is unchanged.
- R5: With mplr_signed=1, product equals bits [2W-1:W-4] of the exact product of mcand and mplr, both read as two's complement.
- R6: With mplr_signed=0, mplr is read as unsigned and product is taken from the same bit field. One multiplicand is added in the finishing pass exactly when the multiplier's top bit is 1.
- R7: The extreme operands are exact: the most negative value, the most positive value, and zero, in both modes.
- R8: Each radix-4 digit is taken from a bit pair plus the bit just below it. It selects one multiplicand when the lower two of those three bits differ, two multiplicands for the patterns 011 and 100, and zero otherwise. It is negative when the top bit is 1. The four stages within an iteration weigh their digits 64, 16, 4 and 1, in that order.
- R9: product changes only on the edge that raises done, and otherwise holds its last value.
- R10: A start given in the done cycle is accepted. Results come back in the order of their starts, each with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand strobe, sampled while busy is 0 |
| mplr_signed | input | 1 | 1: multiplier is two's complement; 0: unsigned |
| mcand | input | W | Multiplicand, two's complement |
| mplr | input | W | Multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | W+4 | Top W+4 bits of the 2W-bit product |

## Verification
The finishing pass of one operation and the acceptance of the next can share a cycle. In the cycle done pulses, busy is already low, so a start given there loads fresh operands on the same edge that the previous result leaves the pipeline. The bench provokes this by issuing operations back to back: its driver waits only for busy to fall. A scoreboard then judges each result by its value and by the exact cycle of its done pulse, which shows that neither operation disturbed the other. A start driven in the middle of a running operation is judged the same way: the bench expects no extra result and no change to the pending one.

// File: rtl/sdmul_pkg.sv
package sdmul_pkg;
  // number of radix-4 stages chained per iteration (one byte of multiplier)
  localparam int STAGES = 4;

  typedef enum logic [1:0] {
    MSEL_ZERO = 2'b00,
    MSEL_ONE  = 2'b01,
    MSEL_TWO  = 2'b10
  } msel_e;

  typedef struct packed {
    msel_e sel;
    logic  neg;
  } stage_ctl_t;
endpackage

// File: rtl/sdmul_recoder.sv
module sdmul_recoder
  import sdmul_pkg::*;
(
  input  logic [2*STAGES:0]         grp,   // [0] is the extra bit below the byte
  output stage_ctl_t [STAGES-1:0]   ctl    // ctl[k] weights 4**k
);
  for (genvar k = 0; k < STAGES; k++) begin : g_pair
    logic [2:0] g;
    msel_e      sel_k;
    assign g = grp[2*k+2 -: 3];
    always_comb begin
      if (g[1] ^ g[0])                   sel_k = MSEL_ONE;
      else if (g == 3'b011 || g == 3'b100) sel_k = MSEL_TWO;
      else                               sel_k = MSEL_ZERO;
    end
    assign ctl[k] = '{sel: sel_k, neg: g[2]};
  end
endmodule

// File: rtl/sdmul_stage.sv
module sdmul_stage #(
  parameter int WD = 28
) (
  input  logic [WD-1:0] p_i,
  input  logic [WD-1:0] n_i,
  input  logic [WD-1:0] y,
  input  logic          neg,
  input  logic          gate,
  output logic [WD-1:0] p_o,
  output logic [WD-1:0] n_o
);
  // Digits: plus bit -> +1, minus bit -> -1. Subtraction is done as
  // -((-X) + Y): swap the vectors, add the conventional operand, swap back.
  logic [WD-1:0] pa, na, w, c, cin, pz, nz;

  assign pa  = neg ? n_i : p_i;
  assign na  = neg ? p_i : n_i;
  // per position t = pa + y - na in -1..2, split as 2*c - w
  assign w   = pa ^ y ^ na;
  assign c   = (na & pa & y) | (~na & (pa | y));
  assign cin = {c[WD-2:0], 1'b0};
  assign pz  = cin & ~w;
  assign nz  = w & ~cin;

  assign p_o = !gate ? p_i : (neg ? nz : pz);
  assign n_o = !gate ? n_i : (neg ? pz : nz);
endmodule

// File: rtl/sdmul_cascade.sv
module sdmul_cascade
  import sdmul_pkg::*;
#(
  parameter int W   = 16,
  parameter int WIN = W + 12
) (
  input  logic [WIN-1:0]          p_i,
  input  logic [WIN-1:0]          n_i,
  input  logic [W-1:0]            ymag,
  input  logic                    ysgn,
  input  stage_ctl_t [STAGES-1:0] ctl,
  input  logic                    assim,
  input  logic                    fix,
  output logic [WIN-1:0]          p_o,
  output logic [WIN-1:0]          n_o
);
  logic [WIN-1:0] pc [STAGES+1];
  logic [WIN-1:0] nc [STAGES+1];

  assign pc[0] = p_i;
  assign nc[0] = n_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int K = STAGES - 1 - s;   // first stage takes the heaviest pair
    logic [WIN-1:0] y_one, y_two, y_sel;
    logic           st_neg, st_gate;

    assign y_one = WIN'(ymag) << (2*K);
    assign y_two = WIN'(ymag) << (2*K + 1);

    always_comb begin
      if (assim) begin
        // finishing pass: first stage may add one multiplicand, rest pass through
        y_sel   = (s == 0 && fix) ? WIN'(ymag) : '0;
        st_neg  = ysgn;
        st_gate = (s == 0);
      end else begin
        unique case (ctl[K].sel)
          MSEL_ONE: y_sel = y_one;
          MSEL_TWO: y_sel = y_two;
          default:  y_sel = '0;
        endcase
        st_neg  = ctl[K].neg ^ ysgn;
        st_gate = 1'b1;
      end
    end

    sdmul_stage #(.WD(WIN)) u_st (
      .p_i (pc[s]),
      .n_i (nc[s]),
      .y   (y_sel),
      .neg (st_neg),
      .gate(st_gate),
      .p_o (pc[s+1]),
      .n_o (nc[s+1])
    );
  end

  assign p_o = pc[STAGES];
  assign n_o = nc[STAGES];
endmodule

// File: rtl/sdmul_top.sv
module sdmul_top
  import sdmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mplr_signed,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplr,
  output logic         busy,
  output logic         done,
  output logic [W+3:0] product
);
  localparam int ITERS = W / 8;
  localparam int LOW   = 8 * ITERS;        // digits that have left the window
  localparam int WIN   = W + 12;           // adding window incl. guard digits
  localparam int AW    = LOW + WIN;
  localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_e;

  state_e                  state;
  logic [CW-1:0]           cnt;
  logic [AW-1:0]           acc_p, acc_n;
  logic [W-1:0]            mreg, ymag, mcand_mag;
  logic                    xbit, ysgn, unsigned_mode;
  logic [2*STAGES:0]       rec_grp;
  stage_ctl_t [STAGES-1:0] rec_ctl;
  logic [WIN-1:0]          win_p, win_n;
  logic [AW-1:0]           nxt_p, nxt_n, diff;

  assign rec_grp   = {mreg[7:0], xbit};
  assign mcand_mag = mcand[W-1] ? ((~mcand) + W'(1)) : mcand;
  assign busy      = (state != ST_IDLE);

  sdmul_recoder u_rec (
    .grp(rec_grp),
    .ctl(rec_ctl)
  );

  sdmul_cascade #(.W(W), .WIN(WIN)) u_cas (
    .p_i  (acc_p[AW-1:LOW]),
    .n_i  (acc_n[AW-1:LOW]),
    .ymag (ymag),
    .ysgn (ysgn),
    .ctl  (rec_ctl),
    .assim(state == ST_FIX),
    .fix  (unsigned_mode & xbit),
    .p_o  (win_p),
    .n_o  (win_n)
  );

  assign nxt_p = {win_p, acc_p[LOW-1:0]};
  assign nxt_n = {win_n, acc_n[LOW-1:0]};
  assign diff  = nxt_p - nxt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      acc_p         <= '0;
      acc_n         <= '0;
      mreg          <= '0;
      ymag          <= '0;
      xbit          <= 1'b0;
      ysgn          <= 1'b0;
      unsigned_mode <= 1'b0;
      done          <= 1'b0;
      product       <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            acc_p         <= '0;
            acc_n         <= '0;
            mreg          <= mplr;
            xbit          <= 1'b0;
            ymag          <= mcand_mag;
            ysgn          <= mcand[W-1];
            unsigned_mode <= !mplr_signed;
            cnt           <= '0;
            state         <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_p <= nxt_p >> 8;
          acc_n <= nxt_n >> 8;
          mreg  <= mreg >> 8;
          xbit  <= mreg[7];
          cnt   <= cnt + CW'(1);
          if (cnt == CW'(ITERS - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          product <= diff[2*W-1:W-4];
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdmul_chk.sv
module sdmul_chk
  import sdmul_pkg::*;
#(
  parameter int W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [W+3:0]            product,
  input logic [2*STAGES:0]       grp,
  input stage_ctl_t [STAGES-1:0] ctl,
  input logic [8*(W/8)+W+11:0]   acc_p,
  input logic [8*(W/8)+W+11:0]   acc_n
);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
  // R5
  digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_p & acc_n) == '0);

  for (genvar k = 0; k < STAGES; k++) begin : g_rc
    // R8
    sel_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[k].sel == MSEL_TWO) |-> (grp[2*k+1] == grp[2*k]));
    // R8
    sel_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[k].sel == MSEL_ONE) |-> (grp[2*k+1] != grp[2*k]));
  end
endmodule

bind sdmul_top sdmul_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .product(product),
  .grp    (rec_grp),
  .ctl    (rec_ctl),
  .acc_p  (acc_p),
  .acc_n  (acc_n)
);

// File: tb/tb_sdmul_top.sv
module tb_sdmul_top;
  localparam int W  = 16;
  localparam int N  = W / 8;
  localparam int PW = W + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mplr_signed = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplr = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [PW-1:0] q_val[$];
  int            q_due[$];
  string         q_tag[$];
  logic [PW-1:0] last_exp = '0;

  sdmul_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mplr_signed(mplr_signed),
    .mcand(mcand), .mplr(mplr), .busy(busy), .done(done), .product(product)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PW-1:0] model(logic [W-1:0] a, logic [W-1:0] b, bit bs);
    longint sa, sbv, p;
    sa  = longint'($signed(a));
    sbv = bs ? longint'($signed(b)) : longint'(b);
    p   = sa * sbv;
    return PW'(p >>> (W - 4));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // driver: waits for an idle cycle, issues one operation, records expectation
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit bs, string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    mcand = a; mplr = b; mplr_signed = bs; start = 1'b1;
    last_exp = model(a, b, bs);
    q_val.push_back(last_exp);
    q_due.push_back(cyc + N + 2);
    q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: scoreboard comparison of value and arrival cycle
  logic [PW-1:0] m_val;
  int            m_due;
  string         m_tag;
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_val.size() == 0) begin
        check("R4 unexpected done", 64'(1), 64'(0));
      end else begin
        m_val = q_val.pop_front();
        m_due = q_due.pop_front();
        m_tag = q_tag.pop_front();
        check(m_tag, 64'(product), 64'(m_val));
        check("R3 done cycle", 64'(cyc), 64'(m_due));
      end
    end
  end

  initial begin
    wait (cyc == 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: actual cycle %0d expected completion earlier", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    int nb;
    seed = 32'h1ACE_0F17;

    repeat (3) @(negedge clk);
    check("R1 busy in reset", 64'(busy), 64'(0));
    check("R1 done in reset", 64'(done), 64'(0));
    check("R1 product in reset", 64'(product), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'(0));
    check("R1 product after reset", 64'(product), 64'(0));

    // R5 signed products
    run_op(16'd3, 16'd5, 1'b1, "R5 small");
    run_op(16'hFFFD, 16'd5, 1'b1, "R5 neg mcand");
    run_op(16'h4000, 16'h4000, 1'b1, "R5 half squared");
    run_op(16'h1234, 16'hFEDC, 1'b1, "R5 mixed sign");
    run_op(16'h0F0F, 16'h8001, 1'b1, "R5 neg mplr");

    // R7 extremes
    run_op(16'h8000, 16'h8000, 1'b1, "R7 min x min");
    run_op(16'h8000, 16'h7FFF, 1'b1, "R7 min x max");
    run_op(16'h7FFF, 16'h7FFF, 1'b1, "R7 max x max");
    run_op(16'h0000, 16'h8000, 1'b1, "R7 zero mcand");
    run_op(16'h8000, 16'hFFFF, 1'b0, "R7 min x unsigned max");
    run_op(16'h7FFF, 16'h0000, 1'b0, "R7 zero mplr");

    // R6 unsigned multiplier, with and without correction
    run_op(16'h7FFF, 16'hFFFF, 1'b0, "R6 top bit set");
    run_op(16'hC000, 16'h8000, 1'b0, "R6 top bit only");
    run_op(16'h2345, 16'h7FFF, 1'b0, "R6 top bit clear");
    run_op(16'hFFFF, 16'hF00F, 1'b0, "R6 minus one");

    // R8 recoding patterns
    run_op(16'h1357, 16'h5555, 1'b1, "R8 0101");
    run_op(16'h1357, 16'hAAAA, 1'b1, "R8 1010");
    run_op(16'hE357, 16'h3333, 1'b1, "R8 0011");
    run_op(16'h1357, 16'hCCCC, 1'b1, "R8 1100");
    run_op(16'h9357, 16'h6666, 1'b0, "R8 0110");
    run_op(16'h1357, 16'h9999, 1'b0, "R8 1001");

    // R2 busy length
    run_op(16'h0101, 16'h0202, 1'b1, "R2 op");
    nb = 1;
    forever begin
      @(negedge clk);
      if (busy) nb++;
      else break;
    end
    check("R2 busy cycles", 64'(nb), 64'(N + 1));

    // R4 start while busy is ignored
    run_op(16'h2468, 16'h1357, 1'b1, "R4 running op");
    @(negedge clk);
    mcand = 16'h7777; mplr = 16'h7777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy || q_val.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R4 no extra done", 64'(q_val.size()), 64'(0));
    check("R4 result kept", 64'(product), 64'(model(16'h2468, 16'h1357, 1'b1)));

    // R10 back to back: each start lands in the previous done cycle
    run_op(16'h0011, 16'h0022, 1'b1, "R10 first");
    run_op(16'hFF00, 16'h00FF, 1'b1, "R10 second");
    run_op(16'h8001, 16'hFFFE, 1'b0, "R10 third");

    // random mix for R5 and R6
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (i % 2 == 0) run_op(seed[31:16], seed[15:0], 1'b1, "R5 random");
      else            run_op(seed[15:0], seed[31:16], 1'b0, "R6 random");
    end

    while (busy || q_val.size() != 0) @(negedge clk);

    // R9 hold after done
    repeat (6) @(negedge clk);
    check("R9 product held", 64'(product), 64'(last_exp));
    check("R9 done low", 64'(done), 64'(0));

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule